// File: doc/BRIEF.md
# I2C Control-Byte Command Deframer

This block is the write-only receive front end of a character display controller that sits on an I2C bus as a slave. It oversamples SCL and SDA with the system clock, recognises START and STOP, and compares the first byte of each transfer with its 7-bit address. If the address matches and the direction bit asks for a write, it acknowledges. It then works through the bytes that follow as a series of control bytes and payload bytes. Each payload byte leaves the block as a single-cycle strobe together with a routing flag. The flag marks the byte as an instruction or as display data.

A control byte carries two meaningful bits: a continuation flag in bit 7 and a register-select flag in bit 6. With continuation set, exactly one payload byte follows, and the byte after it is read as a new control byte. With continuation clear, the register-select value is latched, and every further byte is payload until STOP. A START seen in the middle of a transfer throws away the parse and begins again at the address phase.

The controller is a single state machine. Its states are IDLE (bus free or not addressed), ADDR (receiving the address byte), CTRL (receiving a control byte), DATA1 (receiving the single payload byte that follows a continuing control byte), STREAM (receiving payload until STOP), ACK (holding SDA low through the ninth clock) and IGNORE (a transfer addressed elsewhere or a read). The transitions are:
- START from any state goes to ADDR.
- STOP from any state goes to IDLE.
- ADDR goes to ACK on a write to this address and to IGNORE otherwise.
- CTRL goes to ACK.
- DATA1 and STREAM go to ACK and emit their byte.
- ACK goes to the state that was booked on entry: CTRL after an address byte or after the payload of DATA1, DATA1 or STREAM after a control byte, and STREAM after a streamed byte.

Top module: `i2c_ctrl_deframer`

## Requirements
- R1: A first byte after START equal to {5'b01111, ADDR_LOW, 1'b0} is acknowledged. The block pulls SDA low (sda_oe = 1) while SCL is high for the ninth clock.
- R2: A first byte with different address bits, or with bit 0 (read) set, is not acknowledged. No later byte of that transfer is acknowledged or delivered.
- R3: sda_oe changes only in the cycle after a synchronized SCL falling edge, START or STOP. It is released after the ninth clock falls, before the next data bit.
- R4: Control bytes are acknowledged but never delivered. Only bit 7 (continuation) and bit 6 (RS) are used, and bits 5..0 have no effect.
- R5: A control byte with bit 7 = 1 causes exactly one following byte to be delivered with that RS. The byte after it is treated as a control byte again.
- R6: A control byte with bit 7 = 0 causes every following byte up to STOP to be delivered with the latched RS, and each of those bytes is acknowledged.
- R7: A delivered byte appears on byte_data with the first bit received as bit 7. byte_valid is high for exactly one cycle per byte. byte_rs is 0 for an instruction and 1 for display data.
- R8: After STOP the block stays idle. Bytes clocked without a new START are neither acknowledged nor delivered.
- R9: A repeated START in the middle of a transfer returns the parse to the address phase. The next byte is checked as an address and is not delivered.
- R10: While reset is asserted and right after it, sda_oe and byte_valid are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| byte_valid | output | 1 | One-cycle strobe for a delivered payload byte |
| byte_data | output | BYTE_W | Delivered payload byte |
| byte_rs | output | 1 | 0 = instruction, 1 = display data |

## Verification
The assertions assume the following about the bus:
- SDA changes only while SCL is low, except for START and STOP.
- Each SCL level lasts longer than the synchronizer latency of a few system clocks, so every edge is seen exactly once and in order.
- The bus master releases SDA during the ninth clock.

The bench's bus master keeps within these rules by spacing every SCL and SDA change eight system clocks apart and changing SDA only in the middle of the SCL low phase. The open-drain line is modelled as the master's level ANDed with the inverse of sda_oe. Random transfers mix continuing and final control bytes with random low control bits and payload. Directed transfers cover foreign addresses, reads, bytes clocked after STOP and a repeated START in the middle of a stream.

// File: rtl/deframer_pkg.sv
package deframer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CTRL,
        ST_DATA1,
        ST_STREAM,
        ST_ACK,
        ST_IGNORE
    } dfr_state_e;

    localparam logic [4:0] ADDR_PREFIX = 5'b01111;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_level,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_in;
                    sda_ff <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_in};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign sda_level = sda_s;
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/dfr_shifter.sv
module dfr_shifter #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] shreg,
    output logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (shift_en && cnt != FULL) begin
            shreg <= {shreg[BYTE_W-2:0], bit_in};
            cnt   <= cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL); // R7

endmodule

// File: rtl/i2c_ctrl_deframer.sv
module i2c_ctrl_deframer
    import deframer_pkg::*;
#(
    parameter int         BYTE_W     = 8,
    parameter int         SYNC_STAGE = 2,
    parameter logic [1:0] ADDR_LOW   = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_rs
);
    localparam int         CNT_W     = $clog2(BYTE_W + 1);
    localparam logic [7:0] WRITE_ADR = {ADDR_PREFIX, ADDR_LOW, 1'b0};

    logic              sda_level, scl_rise, scl_fall, start_det, stop_det;
    logic              clear, shift_en, emit, byte_done;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    dfr_state_e        state_q, state_d, after_q, after_d;
    logic              rs_q, rs_d;

    i2c_line_sync #(.STAGES(SYNC_STAGE)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_level (sda_level),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    dfr_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .shift_en (shift_en),
        .bit_in   (sda_level),
        .shreg    (shreg),
        .cnt      (cnt)
    );

    assign byte_done = (cnt == CNT_W'(BYTE_W)) && scl_fall;

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        after_d  = after_q;
        rs_d     = rs_q;
        clear    = 1'b0;
        shift_en = 1'b0;
        emit     = 1'b0;
        if (start_det) begin
            state_d = ST_ADDR;
            clear   = 1'b1;
        end else if (stop_det) begin
            state_d = ST_IDLE;
            clear   = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: ;
                ST_ADDR: begin
                    shift_en = scl_rise;
                    if (byte_done) begin
                        if (shreg[7:0] == WRITE_ADR) begin
                            state_d = ST_ACK;
                            after_d = ST_CTRL;
                        end else begin
                            state_d = ST_IGNORE;
                        end
                    end
                end
                ST_CTRL: begin
                    shift_en = scl_rise;
                    if (byte_done) begin
                        state_d = ST_ACK;
                        rs_d    = shreg[BYTE_W-2];
                        after_d = shreg[BYTE_W-1] ? ST_DATA1 : ST_STREAM;
                    end
                end
                ST_DATA1: begin
                    shift_en = scl_rise;
                    if (byte_done) begin
                        state_d = ST_ACK;
                        after_d = ST_CTRL;
                        emit    = 1'b1;
                    end
                end
                ST_STREAM: begin
                    shift_en = scl_rise;
                    if (byte_done) begin
                        state_d = ST_ACK;
                        after_d = ST_STREAM;
                        emit    = 1'b1;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        state_d = after_q;
                        clear   = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            after_q <= ST_IDLE;
            rs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            after_q <= after_d;
            rs_q    <= rs_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe     <= 1'b0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            byte_rs    <= 1'b0;
        end else begin
            sda_oe     <= (state_d == ST_ACK);
            byte_valid <= emit;
            if (emit) begin
                byte_data <= shreg;
                byte_rs   <= rs_d;
            end
        end
    end

    AST_OE_RISE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall)); // R3
    AST_OE_FALL_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det))); // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R7
    AST_VALID_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> sda_oe); // R6
    AST_READ_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && byte_done && !start_det && !stop_det && shreg[0]) |=> !sda_oe); // R2
    AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_ADDR && !byte_valid)); // R9
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE && !sda_oe)); // R8

endmodule

// File: tb/tb_i2c_ctrl_deframer.sv
module tb_i2c_ctrl_deframer;
    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 8;
    localparam logic [1:0] ADR_LO     = 2'b10;
    localparam logic [7:0] WADDR      = {5'b01111, ADR_LO, 1'b0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe, byte_valid, byte_rs;
    logic [7:0] byte_data;
    wire        sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [8:0] got_q[$];
    logic [8:0] exp_q[$];
    logic [7:0] tx[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ctrl_deframer #(.BYTE_W(8), .SYNC_STAGE(2), .ADDR_LOW(ADR_LO)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_rs    (byte_rs)
    );

    always @(negedge clk) if (rst_n && byte_valid) got_q.push_back({byte_rs, byte_data});

    function automatic logic [8:0] pack(input logic rs, input logic [7:0] d);
        return {rs, d};
    endfunction

    function automatic logic [7:0] ctrl(input logic co, input logic rs, input logic [5:0] junk);
        return {co, rs, junk};
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1; ticks(Q);
            scl_m = 1'b1; ticks(Q);
        end
        sda_m = 1'b0; ticks(Q);
        scl_m = 1'b0; ticks(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; ticks(Q);
        scl_m = 1'b1; ticks(Q);
        sda_m = 1'b1; ticks(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit ack;
        for (int i = 7; i >= 0; i--) begin
            ticks(Q); sda_m = b[i];
            ticks(Q); scl_m = 1'b1;
            ticks(2*Q); scl_m = 1'b0;
        end
        ticks(Q); sda_m = 1'b1;
        ticks(Q); scl_m = 1'b1;
        ticks(Q); ack = ~sda_line;
        check(ack == exp_ack, req, "ack bit", int'(ack), int'(exp_ack));
        ticks(Q); scl_m = 1'b0;
        ticks(Q);
        check(sda_oe == 1'b0, "R3", "sda released after ninth clock", int'(sda_oe), 0);
    endtask

    task automatic compare(input string req);
        check(got_q.size() == exp_q.size(), req, "delivered count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check(got_q[i] == exp_q[i], req, "delivered {rs,byte}", int'(got_q[i]), int'(exp_q[i]));
    endtask

    task automatic run_frame(input bit ack_all, input string req);
        got_q.delete();
        bus_start();
        foreach (tx[i]) send_byte(tx[i], ack_all, req);
        bus_stop();
        ticks(4);
        compare(req);
    endtask

    initial begin
        void'($urandom(32'd1234));
        ticks(3);
        check(sda_oe == 1'b0 && byte_valid == 1'b0, "R10", "outputs in reset", int'({sda_oe, byte_valid}), 0);
        rst_n = 1'b1;
        ticks(4);
        check(sda_oe == 1'b0 && byte_valid == 1'b0, "R10", "outputs after reset", int'({sda_oe, byte_valid}), 0);

        // R1 R4 R5 R6 R7: continuing pairs then a final control and a stream
        tx = '{WADDR, ctrl(1'b1, 1'b0, 6'h3F), 8'hA5, ctrl(1'b1, 1'b1, 6'h00), 8'h3C,
               ctrl(1'b0, 1'b1, 6'h15), 8'h80, 8'h01, 8'hFF};
        exp_q = '{pack(1'b0, 8'hA5), pack(1'b1, 8'h3C), pack(1'b1, 8'h80), pack(1'b1, 8'h01), pack(1'b1, 8'hFF)};
        run_frame(1'b1, "R5");

        // R6: final control with RS=0, stream of instructions; a control-looking byte stays data
        tx = '{WADDR, ctrl(1'b0, 1'b0, 6'h00), 8'hC0, 8'h12};
        exp_q = '{pack(1'b0, 8'hC0), pack(1'b0, 8'h12)};
        run_frame(1'b1, "R6");

        // R4: control byte alone delivers nothing
        tx = '{WADDR, ctrl(1'b1, 1'b1, 6'h2A)};
        exp_q.delete();
        run_frame(1'b1, "R4");

        // R2: foreign address and read direction
        tx = '{{5'b01111, ~ADR_LO, 1'b0}, ctrl(1'b0, 1'b1, 6'h0), 8'h55};
        exp_q.delete();
        run_frame(1'b0, "R2");
        tx = '{{WADDR[7:1], 1'b1}, ctrl(1'b0, 1'b1, 6'h0), 8'h66};
        run_frame(1'b0, "R2");

        // R8: bytes clocked after STOP with no START
        got_q.delete();
        scl_m = 1'b0; ticks(Q);
        send_byte(WADDR, 1'b0, "R8");
        send_byte(8'h44, 1'b0, "R8");
        bus_stop();
        ticks(4);
        exp_q.delete();
        compare("R8");

        // R9: repeated START in the middle of a stream
        got_q.delete();
        bus_start();
        send_byte(WADDR, 1'b1, "R9");
        send_byte(ctrl(1'b0, 1'b1, 6'h0), 1'b1, "R9");
        send_byte(8'h11, 1'b1, "R9");
        bus_start();
        send_byte(WADDR, 1'b1, "R9");
        send_byte(ctrl(1'b1, 1'b0, 6'h0), 1'b1, "R9");
        send_byte(8'h22, 1'b1, "R9");
        bus_stop();
        ticks(4);
        exp_q = '{pack(1'b1, 8'h11), pack(1'b0, 8'h22)};
        compare("R9");

        // Random transfers
        for (int t = 0; t < 16; t++) begin
            int nseg;
            tx.delete(); exp_q.delete();
            tx.push_back(WADDR);
            nseg = $urandom_range(0, 3);
            for (int s = 0; s < nseg; s++) begin
                logic rs; logic [7:0] d;
                rs = 1'($urandom); d = 8'($urandom);
                tx.push_back(ctrl(1'b1, rs, 6'($urandom)));
                tx.push_back(d);
                exp_q.push_back(pack(rs, d));
            end
            if ($urandom_range(0, 1) == 1) begin
                logic rs; int n;
                rs = 1'($urandom);
                n = $urandom_range(0, 4);
                tx.push_back(ctrl(1'b0, rs, 6'($urandom)));
                for (int k = 0; k < n; k++) begin
                    logic [7:0] d;
                    d = 8'($urandom);
                    tx.push_back(d);
                    exp_q.push_back(pack(rs, d));
                end
            end
            run_frame(1'b1, "R7");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule